// File: doc/BRIEF.md
# Interlocked Memory Bus Master

This block lets a core run one memory word transfer at a time over a bus where the master and the memory each raise and lower a valid line, and each side waits for the other before it moves on. The core gives the block a request: an address, a read/write choice, a flag that says whether the access is an instruction fetch or a data access, and the write data. The block puts that request on the bus and holds it there until the memory answers. For a read, it returns the word from the memory with a one-cycle completion pulse.

The request side uses a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no transfer is in progress, so the core is held off, and a request offered during a transfer is simply not taken. The response side has no back-pressure. The core must accept `rsp_valid`/`rsp_rdata` in the cycle they appear.

Each transfer passes through four steps. First the master raises `bus_cpu_valid`. The memory then raises `bus_mem_valid`. After that the master lowers `bus_cpu_valid`, and finally the memory lowers `bus_mem_valid`. Only after this last step may the next transfer start. Every bus line is sampled on a rising clock edge.

Top module: `handshake_bus_master`

## Requirements
- R1: `req_ready` is high exactly when no transfer is in progress. A request is accepted on an edge where `req_valid` and `req_ready` are both high. From the next cycle, `bus_cpu_valid` is high and the request's address is on `bus_addr`. `bus_rw` carries the request's direction, with 0 meaning read and 1 meaning write.
- R2: `bus_instdata` is 0 for an instruction fetch, which is a request with `req_is_data` = 0. It is 1 for a data access. A write always drives `bus_instdata` to 1, whatever value `req_is_data` has.
- R3: While `bus_cpu_valid` is high, `bus_addr`, `bus_rw`, `bus_instdata` and `bus_wdata` do not change.
- R4: `bus_cpu_valid` stays high until an edge where `bus_mem_valid` is sampled high. It is low in the cycle after that edge.
- R5: Read data is taken from `bus_rdata` on the first edge where `bus_mem_valid` is high. In the cycle after that edge, `rsp_valid` is high for exactly one cycle, and `rsp_rdata` then holds the captured word.
- R6: Once `bus_cpu_valid` has fallen, no new transfer starts until an edge has sampled `bus_mem_valid` low. At that edge the block returns to idle.
- R7: A request offered while a transfer is in progress is ignored. `busy` is high, `req_ready` is low, and the fields on the bus stay those of the transfer already under way.
- R8: During a write, `bus_wdata` carries the request's write data. During a read, `bus_wdata` is all zeros, and the bus data lines belong to the memory.
- R9: After reset, `bus_cpu_valid`, `rsp_valid` and `busy` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Word to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Word returned by a read |
| busy | output | 1 | A transfer is in progress |
| bus_addr | output | ADDR_W | Bus address |
| bus_rw | output | 1 | Bus direction, 1 = write |
| bus_instdata | output | 1 | 0 = instruction fetch, 1 = data access |
| bus_cpu_valid | output | 1 | Master's valid line |
| bus_wdata | output | DATA_W | Write data toward memory |
| bus_mem_valid | input | 1 | Memory's valid line |
| bus_rdata | input | DATA_W | Read data from memory |

## Verification
The bench drives the bus with a memory model whose delays before raising and before lowering its valid line are random, from zero extra cycles up to three. Three failures are targeted directly:

- **Early release.** A master that drops `bus_cpu_valid` before seeing `bus_mem_valid` is caught by the memory model.
- **Early restart.** A master that starts a new transfer while `bus_mem_valid` is still high shows a valid line that rises too early.
- **Late capture.** The memory model changes `bus_rdata` after the capture edge, so a design that samples read data late returns a wrong word.

The core side offers requests on random cycles with fields that change every cycle. A design that takes a request while busy, or that lets the bus fields follow the core's inputs, puts a wrong value on the bus. Writes marked as instruction fetches check that `bus_instdata` is forced to 1.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_REQUEST = 2'd1,
    PH_RELEASE = 2'd2
  } hbm_phase_e;
endpackage

// File: rtl/hbm_sequencer.sv
module hbm_sequencer
  import hbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       mem_valid,
  output hbm_phase_e phase,
  output logic       cpu_valid,
  output logic       capture
);
  hbm_phase_e phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE:    if (start)      phase_q <= PH_REQUEST;
        PH_REQUEST: if (mem_valid)  phase_q <= PH_RELEASE;
        PH_RELEASE: if (!mem_valid) phase_q <= PH_IDLE;
        default:                    phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase     = phase_q;
  assign cpu_valid = (phase_q == PH_REQUEST);
  // the first edge of mem_valid while requesting completes the data phase
  assign capture   = (phase_q == PH_REQUEST) && mem_valid;
endmodule

// File: rtl/hbm_request_hold.sv
module hbm_request_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              write,
  input  logic              is_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rw,
  output logic              bus_instdata,
  output logic [DATA_W-1:0] bus_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr     <= '0;
      bus_rw       <= 1'b0;
      bus_instdata <= 1'b0;
      bus_wdata    <= '0;
    end else if (load) begin
      bus_addr     <= addr;
      bus_rw       <= write;
      // writes are never instruction fetches
      bus_instdata <= write | is_data;
      bus_wdata    <= write ? wdata : '0;
    end
  end
endmodule

// File: rtl/hbm_response.sv
module hbm_response #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              is_read,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture && is_read) rsp_rdata <= bus_rdata;
    end
  end
endmodule

// File: rtl/handshake_bus_master.sv
module handshake_bus_master
  import hbm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_is_data,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rw,
  output logic              bus_instdata,
  output logic              bus_cpu_valid,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_mem_valid,
  input  logic [DATA_W-1:0] bus_rdata
);
  hbm_phase_e phase;
  logic       accept;
  logic       capture;

  assign req_ready = (phase == PH_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;

  hbm_sequencer u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .mem_valid (bus_mem_valid),
    .phase     (phase),
    .cpu_valid (bus_cpu_valid),
    .capture   (capture)
  );

  hbm_request_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk          (clk),
    .rst          (rst),
    .load         (accept),
    .write        (req_write),
    .is_data      (req_is_data),
    .addr         (req_addr),
    .wdata        (req_wdata),
    .bus_addr     (bus_addr),
    .bus_rw       (bus_rw),
    .bus_instdata (bus_instdata),
    .bus_wdata    (bus_wdata)
  );

  hbm_response #(.DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .is_read   (!bus_rw),
    .bus_rdata (bus_rdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/hbm_checker.sv
module hbm_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              rsp_valid,
  input logic              bus_cpu_valid,
  input logic              bus_mem_valid,
  input logic              bus_rw,
  input logic              bus_instdata,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata
);
  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> bus_cpu_valid);

  p_write_inst_r2: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid && bus_rw |-> bus_instdata);

  p_fields_stable_r3: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid && $past(bus_cpu_valid) |->
      $stable(bus_addr) && $stable(bus_rw) && $stable(bus_instdata) && $stable(bus_wdata));

  p_hold_valid_r4: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid && !bus_mem_valid |=> bus_cpu_valid);

  p_drop_valid_r4: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid && bus_mem_valid |=> !bus_cpu_valid);

  p_done_follows_r5: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid && bus_mem_valid |=> rsp_valid);

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  p_no_restart_r6: assert property (@(posedge clk) disable iff (rst)
    !bus_cpu_valid && bus_mem_valid |=> !bus_cpu_valid);

  p_closed_while_busy_r7: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid |-> busy && !req_ready);

  p_read_no_drive_r8: assert property (@(posedge clk) disable iff (rst)
    bus_cpu_valid && !bus_rw |-> bus_wdata == '0);
endmodule

bind handshake_bus_master hbm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .busy          (busy),
  .rsp_valid     (rsp_valid),
  .bus_cpu_valid (bus_cpu_valid),
  .bus_mem_valid (bus_mem_valid),
  .bus_rw        (bus_rw),
  .bus_instdata  (bus_instdata),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata)
);

// File: tb/handshake_bus_master_tb.sv
`timescale 1ns/100ps
module handshake_bus_master_tb;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int RUN_CYCLES = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_is_data = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, busy, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] bus_addr;
  logic          bus_rw, bus_instdata, bus_cpu_valid;
  logic [DW-1:0] bus_wdata;
  logic          bus_mem_valid = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  handshake_bus_master #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_is_data(req_is_data), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .busy(busy), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_instdata(bus_instdata), .bus_cpu_valid(bus_cpu_valid),
    .bus_wdata(bus_wdata), .bus_mem_valid(bus_mem_valid), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // reference model: phase 0 idle, 1 requesting, 2 releasing
  int            m_phase = 0;
  bit            m_cv = 0, m_rsp = 0, m_wr = 0, m_isd = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd = '0, m_rdata = '0;
  // memory model state
  int r_st = 0;
  int r_cnt = 0;

  always @(negedge clk) begin
    if (rst) begin
      m_phase = 0; m_cv = 0; m_rsp = 0; r_st = 0; bus_mem_valid = 1'b0;
      chk(!bus_cpu_valid, "R9", "cpu_valid in reset", 64'(bus_cpu_valid), 0);
      chk(!rsp_valid, "R9", "rsp_valid in reset", 64'(rsp_valid), 0);
      chk(!busy, "R9", "busy in reset", 64'(busy), 0);
      chk(req_ready, "R9", "ready in reset", 64'(req_ready), 1);
    end else begin
      chk(req_ready == (m_phase == 0), "R1", "req_ready", 64'(req_ready), 64'(m_phase == 0));
      chk(busy == (m_phase != 0), "R7", "busy", 64'(busy), 64'(m_phase != 0));
      chk(bus_cpu_valid == m_cv, "R4", "cpu_valid", 64'(bus_cpu_valid), 64'(m_cv));
      chk(rsp_valid == m_rsp, "R5", "rsp_valid", 64'(rsp_valid), 64'(m_rsp));
      if (m_rsp && !m_wr)
        chk(rsp_rdata == m_rdata, "R5", "rsp_rdata", 64'(rsp_rdata), 64'(m_rdata));
      if (m_cv) begin
        chk(bus_addr == m_addr, "R1", "bus_addr", 64'(bus_addr), 64'(m_addr));
        chk(bus_rw == m_wr, "R1", "bus_rw", 64'(bus_rw), 64'(m_wr));
        chk(bus_instdata == (m_wr | m_isd), "R2", "bus_instdata",
            64'(bus_instdata), 64'(m_wr | m_isd));
        chk(bus_wdata == (m_wr ? m_wd : '0), "R8", "bus_wdata",
            64'(bus_wdata), 64'(m_wr ? m_wd : '0));
      end

      // memory side: every move waits for the other side to be seen on an edge
      case (r_st)
        0: if (bus_cpu_valid) begin r_cnt = $urandom_range(0, 3); r_st = 1; end
        1: begin
          chk(bus_cpu_valid, "R4", "valid dropped before answer", 64'(bus_cpu_valid), 1);
          if (r_cnt == 0) begin bus_mem_valid = 1'b1; bus_rdata = DW'($urandom); r_st = 2; end
          else r_cnt--;
        end
        2: if (!bus_cpu_valid) begin
          bus_rdata = DW'($urandom);   // stale word after the capture edge (R5)
          r_cnt = $urandom_range(0, 3); r_st = 3;
        end
        default: begin
          chk(!bus_cpu_valid, "R6", "restart while mem_valid high", 64'(bus_cpu_valid), 0);
          if (r_cnt == 0) begin bus_mem_valid = 1'b0; r_st = 0; end
          else r_cnt--;
        end
      endcase

      // model step for the coming edge
      m_rsp = 0;
      case (m_phase)
        0: if (req_valid) begin
          m_addr = req_addr; m_wr = req_write; m_isd = req_is_data; m_wd = req_wdata;
          m_cv = 1; m_phase = 1;
        end
        1: if (bus_mem_valid) begin
          if (!m_wr) m_rdata = bus_rdata;
          m_rsp = 1; m_cv = 0; m_phase = 2;
        end
        default: if (!bus_mem_valid) m_phase = 0;
      endcase
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    // directed: fetch read, write flagged as fetch (R2), data read
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = (k == 1); req_is_data = (k == 2);
      req_addr = AW'(32'h100 + k * 4); req_wdata = DW'(32'hA5A5_0000 + k);
      @(posedge clk); #1;
      req_valid = 1'b0;
      while (busy) begin @(posedge clk); #1; end
    end
    // random traffic: fields move every cycle, requests during busy must be ignored (R7)
    for (int c = 0; c < RUN_CYCLES; c++) begin
      @(posedge clk); #1;
      req_valid   = ($urandom_range(0, 2) == 0);
      req_write   = $urandom_range(0, 1) == 1;
      req_is_data = $urandom_range(0, 1) == 1;
      req_addr    = AW'($urandom);
      req_wdata   = DW'($urandom);
    end
    @(posedge clk); #1 req_valid = 1'b0;
    repeat (20) @(posedge clk);
    wrap_up();
  end

  initial begin
    #(4 * 50000);
    n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    wrap_up();
  end
endmodule